// File: doc/BRIEF.md
# Four-Phase Bus Read/Write Handshake Controller

This block is a clocked controller that sits between a bus master and a peripheral device with its data transceiver. The master requests a transfer by raising either a read strobe or a write strobe. The controller then sequences three outputs: a request to the device, an enable for the transceiver and an acknowledge back to the master. The device answers the request on its own acknowledge line. Every signal follows a four-phase return-to-zero discipline, and each output moves at most once per clock edge, so the handshake order can be seen directly on the pins.

All three inputs pass through a synchronizer chain before any decision uses them. In the read sequence, two phases present the same pattern on the visible lines. A private phase bit separates them. The bit is set just before the bus acknowledge drops, and cleared before the device request rises in a read, or before the transceiver enable drops in a write. It therefore toggles once in each direction in every transfer.

The controller watches the synchronized inputs for illegal moves. When it sees one, it raises a sticky error flag and freezes its outputs until reset.

Top module: `hs_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it is released, dev_req_o, xcvr_en_o, bus_ack_o and proto_err_o are all 0.
- R2: A read produces output transitions in this order: dev_req_o rises, xcvr_en_o rises, bus_ack_o rises, xcvr_en_o falls, dev_req_o falls, bus_ack_o falls.
  - xcvr_en_o rises only once the device acknowledge is high.
  - xcvr_en_o falls only once the read strobe is low.
  - bus_ack_o falls only once the device acknowledge is low.
- R3: A write produces output transitions in this order: xcvr_en_o rises, dev_req_o rises, xcvr_en_o falls, bus_ack_o rises, bus_ack_o falls, dev_req_o falls.
  - xcvr_en_o falls only once the device acknowledge is high.
  - bus_ack_o falls only once the write strobe is low.
- R4: Across any single clock edge, at most one of dev_req_o, xcvr_en_o and bus_ack_o changes.
- R5: dev_req_o rises only while the synchronized device acknowledge is low.
- R6: If both synchronized strobes are high at the same time, proto_err_o is 1 from the next edge on.
- R7: Each of the following sets proto_err_o on the next edge:
  - the synchronized device acknowledge rises while dev_req_o is 0, or falls while dev_req_o is 1;
  - a synchronized strobe rises while bus_ack_o is 1;
  - a synchronized strobe falls while bus_ack_o is 0.
- R8: Once proto_err_o is 1, it and all three handshake outputs hold their values until reset, whatever the inputs do.
- R9: Each input change reaches the controller after SYNC_STAGES edges. The outputs match a cycle-accurate model of R2 and R3 at every clock, including the extra cycle that clearing the phase bit costs at the start of a read, and after the device acknowledge rises in a write.
- R10: A transfer starts (dev_req_o or xcvr_en_o rises) only while bus_ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe_i | input | 1 | Read request from the bus master (asynchronous) |
| wr_strobe_i | input | 1 | Write request from the bus master (asynchronous) |
| dev_ack_i | input | 1 | Acknowledge from the device (asynchronous) |
| dev_req_o | output | 1 | Request to the device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
The bench builds the controller with the default two-stage synchronizer, so each input change shows up at the outputs three edges after it is driven. The device model answers requests after random delays of zero to four cycles. With that spread, the device acknowledge arrives both before and after strobe changes have crossed the synchronizer, and back-to-back transfers begin while the device is still releasing its acknowledge from the previous one. The two-stage depth also keeps the violation tests deterministic: an early strobe drop and a strobe rising under an active bus acknowledge both land in known controller phases.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_XEN,
        ST_RD_ACK,
        ST_RD_XOFF,
        ST_RD_REQOFF,
        ST_RD_FIN,
        ST_WR_XEN,
        ST_WR_REQ,
        ST_WR_XOFF,
        ST_WR_ACK,
        ST_WR_SET,
        ST_WR_ACKOFF,
        ST_WR_DONE
    } hs_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic dack;
    } hs_in_t;

    typedef struct packed {
        logic req;
        logic xen;
        logic ack;
    } hs_out_t;

    localparam int HS_IN_W = $bits(hs_in_t);

    function automatic hs_out_t drive_of(hs_state_e s);
        hs_out_t o;
        o = '0;
        case (s)
            ST_RD_REQ:    o = '{req: 1'b1, xen: 1'b0, ack: 1'b0};
            ST_RD_XEN:    o = '{req: 1'b1, xen: 1'b1, ack: 1'b0};
            ST_RD_ACK:    o = '{req: 1'b1, xen: 1'b1, ack: 1'b1};
            ST_RD_XOFF:   o = '{req: 1'b1, xen: 1'b0, ack: 1'b1};
            ST_RD_REQOFF: o = '{req: 1'b0, xen: 1'b0, ack: 1'b1};
            ST_RD_FIN:    o = '{req: 1'b0, xen: 1'b0, ack: 1'b1};
            ST_WR_XEN:    o = '{req: 1'b0, xen: 1'b1, ack: 1'b0};
            ST_WR_REQ:    o = '{req: 1'b1, xen: 1'b1, ack: 1'b0};
            ST_WR_XOFF:   o = '{req: 1'b1, xen: 1'b0, ack: 1'b0};
            ST_WR_ACK:    o = '{req: 1'b1, xen: 1'b0, ack: 1'b1};
            ST_WR_SET:    o = '{req: 1'b1, xen: 1'b0, ack: 1'b1};
            ST_WR_ACKOFF: o = '{req: 1'b1, xen: 1'b0, ack: 1'b0};
            default:      o = '0;
        endcase
        return o;
    endfunction

    function automatic logic went_up(logic now_v, logic before_v);
        return now_v & ~before_v;
    endfunction

    function automatic logic went_down(logic now_v, logic before_v);
        return ~now_v & before_v;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    // STAGES must be at least 2
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i[b]};
            end
            assign q_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hs_rule_mon.sv
module hs_rule_mon
    import hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_in_t  now_i,
    input  hs_out_t drv_i,
    output logic    bad_o,
    output logic    err_o
);
    hs_in_t prev_q;
    logic   err_q;
    logic   strobe_up, strobe_dn, dack_up, dack_dn;

    always_comb begin
        strobe_up = went_up(now_i.rd, prev_q.rd)   | went_up(now_i.wr, prev_q.wr);
        strobe_dn = went_down(now_i.rd, prev_q.rd) | went_down(now_i.wr, prev_q.wr);
        dack_up   = went_up(now_i.dack, prev_q.dack);
        dack_dn   = went_down(now_i.dack, prev_q.dack);
        bad_o     = (now_i.rd & now_i.wr)
                  | (strobe_up & drv_i.ack)
                  | (strobe_dn & ~drv_i.ack)
                  | (dack_up & ~drv_i.req)
                  | (dack_dn & drv_i.req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            err_q  <= 1'b0;
        end else begin
            prev_q <= now_i;
            err_q  <= err_q | bad_o;
        end
    end

    assign err_o = err_q;
endmodule

// File: rtl/hs_seq.sv
module hs_seq
    import hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_in_t  now_i,
    input  logic    hold_i,
    output hs_out_t drv_o,
    output logic    phase_o
);
    hs_state_e st_q, st_d;
    logic      ph_q, ph_d;

    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        if (!hold_i) begin
            case (st_q)
                ST_IDLE: begin
                    if (now_i.rd) begin
                        if (ph_q)             ph_d = 1'b0;
                        else if (!now_i.dack) st_d = ST_RD_REQ;
                    end else if (now_i.wr) begin
                        st_d = ST_WR_XEN;
                    end
                end
                ST_RD_REQ:    if (now_i.dack) st_d = ST_RD_XEN;
                ST_RD_XEN:    st_d = ST_RD_ACK;
                ST_RD_ACK:    if (!now_i.rd) st_d = ST_RD_XOFF;
                ST_RD_XOFF:   st_d = ST_RD_REQOFF;
                ST_RD_REQOFF: begin
                    if (!now_i.dack) begin
                        ph_d = 1'b1;
                        st_d = ST_RD_FIN;
                    end
                end
                ST_RD_FIN:    st_d = ST_IDLE;
                ST_WR_XEN:    if (!now_i.dack) st_d = ST_WR_REQ;
                ST_WR_REQ: begin
                    if (now_i.dack) begin
                        if (ph_q) ph_d = 1'b0;
                        else      st_d = ST_WR_XOFF;
                    end
                end
                ST_WR_XOFF:   st_d = ST_WR_ACK;
                ST_WR_ACK: begin
                    if (!now_i.wr) begin
                        ph_d = 1'b1;
                        st_d = ST_WR_SET;
                    end
                end
                ST_WR_SET:    st_d = ST_WR_ACKOFF;
                ST_WR_ACKOFF: st_d = ST_WR_DONE;
                ST_WR_DONE:   if (!now_i.dack) st_d = ST_IDLE;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            ph_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
        end
    end

    assign drv_o   = drive_of(st_q);
    assign phase_o = ph_q;
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe_i,
    input  logic wr_strobe_i,
    input  logic dev_ack_i,
    output logic dev_req_o,
    output logic xcvr_en_o,
    output logic bus_ack_o,
    output logic proto_err_o
);
    logic [HS_IN_W-1:0] raw_in, syn_in;
    hs_in_t             in_s;
    hs_out_t            drv;
    logic               bad, err, phase_bit;

    assign raw_in = {rd_strobe_i, wr_strobe_i, dev_ack_i};
    assign in_s   = hs_in_t'(syn_in);

    hs_sync #(.WIDTH(HS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_in)
    );

    hs_rule_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .now_i (in_s),
        .drv_i (drv),
        .bad_o (bad),
        .err_o (err)
    );

    hs_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .now_i   (in_s),
        .hold_i  (err | bad),
        .drv_o   (drv),
        .phase_o (phase_bit)
    );

    assign dev_req_o   = drv.req;
    assign xcvr_en_o   = drv.xen;
    assign bus_ack_o   = drv.ack;
    assign proto_err_o = err;

    logic unused_phase;
    assign unused_phase = phase_bit;
endmodule

// File: rtl/hs_ctrl_chk.sv
module hs_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic rd_s,
    input logic wr_s,
    input logic ack_s,
    input logic req,
    input logic xen,
    input logic ack,
    input logic err
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!req && !xen && !ack && !err));

    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        $countones({req, xen, ack} ^ $past({req, xen, ack})) <= 1);

    a_r5_req_after_ack_low: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> !$past(ack_s));

    a_r6_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        (rd_s && wr_s) |=> err);

    a_r7_ack_without_req: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_s) && !req) |=> err);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r8_err_freeze: assert property (@(posedge clk) disable iff (rst)
        err |=> $stable({req, xen, ack}));

    a_r10_start_when_ack_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(req) || $rose(xen)) |-> !ack);
endmodule

bind hs_ctrl hs_ctrl_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .rd_s  (in_s.rd),
    .wr_s  (in_s.wr),
    .ack_s (in_s.dack),
    .req   (dev_req_o),
    .xen   (xcvr_en_o),
    .ack   (bus_ack_o),
    .err   (proto_err_o)
);

// File: tb/hs_ctrl_bench.sv
`timescale 1ns/1ps
module hs_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd = 1'b0, wr = 1'b0, dack = 1'b0;
    logic dev_req_o, xcvr_en_o, bus_ack_o, proto_err_o;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    hs_ctrl u_hs_ctrl (
        .clk(clk), .rst(rst),
        .rd_strobe_i(rd), .wr_strobe_i(wr), .dev_ack_i(dack),
        .dev_req_o(dev_req_o), .xcvr_en_o(xcvr_en_o),
        .bus_ack_o(bus_ack_o), .proto_err_o(proto_err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model (behavioural, two-cycle input delay)
    int m_st = 0;
    bit m_req = 0, m_xen = 0, m_ack = 0, m_ph = 0, m_err = 0, m_bad = 0;
    bit [2:0] h1 = 0, h2 = 0, pv = 0, cv = 0;   // {rd, wr, dack}

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_req = 0; m_xen = 0; m_ack = 0; m_ph = 0; m_err = 0;
            h1 = 0; h2 = 0; pv = 0;
        end else begin
            cv = h2;
            m_bad = (cv[2] && cv[1])
                 || (((cv[2] && !pv[2]) || (cv[1] && !pv[1])) && m_ack)
                 || (((!cv[2] && pv[2]) || (!cv[1] && pv[1])) && !m_ack)
                 || (cv[0] && !pv[0] && !m_req)
                 || (!cv[0] && pv[0] && m_req);
            if (!m_err && !m_bad) begin
                case (m_st)
                    0:  if (cv[2]) begin
                            if (m_ph) m_ph = 0;
                            else if (!cv[0]) begin m_req = 1; m_st = 1; end
                        end else if (cv[1]) begin m_xen = 1; m_st = 20; end
                    1:  if (cv[0]) begin m_xen = 1; m_st = 2; end
                    2:  begin m_ack = 1; m_st = 3; end
                    3:  if (!cv[2]) begin m_xen = 0; m_st = 4; end
                    4:  begin m_req = 0; m_st = 5; end
                    5:  if (!cv[0]) begin m_ph = 1; m_st = 6; end
                    6:  begin m_ack = 0; m_st = 0; end
                    20: if (!cv[0]) begin m_req = 1; m_st = 21; end
                    21: if (cv[0]) begin
                            if (m_ph) m_ph = 0;
                            else begin m_xen = 0; m_st = 22; end
                        end
                    22: begin m_ack = 1; m_st = 23; end
                    23: if (!cv[1]) begin m_ph = 1; m_st = 24; end
                    24: begin m_ack = 0; m_st = 25; end
                    25: begin m_req = 0; m_st = 26; end
                    26: if (!cv[0]) m_st = 0;
                    default: m_st = 0;
                endcase
            end
            if (m_bad) m_err = 1;
            pv = cv;
            h2 = h1;
            h1 = {rd, wr, dack};
        end
    end

    // ---------------- per-clock compare and transition log
    int log_q[$];
    bit [2:0] last_o = 0, cur_o = 0, diff_o = 0;

    initial forever begin
        @(negedge clk);
        cur_o = {dev_req_o, xcvr_en_o, bus_ack_o};
        if (!rst) begin
            chk({cur_o, proto_err_o} == {m_req, m_xen, m_ack, m_err},
                "R9 model match", int'({cur_o, proto_err_o}), int'({m_req, m_xen, m_ack, m_err}));
            diff_o = cur_o ^ last_o;
            if (diff_o != 0) begin
                chk($countones(diff_o) <= 1, "R4 one change", $countones(diff_o), 1);
                if (cur_o[2] && !last_o[2]) begin
                    log_q.push_back(1);
                    chk(!dack, "R5 req rise with device ack low", int'(dack), 0);
                    chk(!bus_ack_o, "R10 start with bus ack low", int'(bus_ack_o), 0);
                end
                if (!cur_o[2] && last_o[2]) log_q.push_back(2);
                if (cur_o[1] && !last_o[1]) begin
                    log_q.push_back(3);
                    chk(!bus_ack_o, "R10 start with bus ack low", int'(bus_ack_o), 0);
                end
                if (!cur_o[1] && last_o[1]) log_q.push_back(4);
                if (cur_o[0] && !last_o[0]) log_q.push_back(5);
                if (!cur_o[0] && last_o[0]) log_q.push_back(6);
            end
        end
        last_o = cur_o;
    end

    // ---------------- device model: follows the request after a random delay
    bit dev_on = 1;
    bit dack_force = 0;
    int dcnt = 0;

    initial forever begin
        @(negedge clk);
        if (rst) begin
            dack = 0; dcnt = 0;
        end else if (!dev_on) begin
            dack = dack_force;
        end else if (dev_req_o != dack) begin
            if (dcnt == 0) begin
                dack = dev_req_o;
                dcnt = $urandom_range(0, 4);
            end else begin
                dcnt--;
            end
        end
    end

    // ---------------- master tasks
    int exp_rd[6] = '{1, 3, 5, 4, 2, 6};   // R2
    int exp_wr[6] = '{3, 1, 4, 5, 6, 2};   // R3

    task automatic settle();
        while (dev_req_o || xcvr_en_o || bus_ack_o || dack) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_cycle(input bit is_wr, input bit check_order);
        @(negedge clk);
        while (bus_ack_o) @(negedge clk);
        if (check_order) log_q.delete();
        if (is_wr) wr = 1; else rd = 1;
        while (!bus_ack_o) @(negedge clk);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (is_wr) wr = 0; else rd = 0;
        while (bus_ack_o) @(negedge clk);
        if (check_order) begin
            settle();
            chk(log_q.size() == 6, is_wr ? "R3 transition count" : "R2 transition count",
                log_q.size(), 6);
            for (int i = 0; i < 6 && i < log_q.size(); i++) begin
                if (is_wr) chk(log_q[i] == exp_wr[i], "R3 write order", log_q[i], exp_wr[i]);
                else       chk(log_q[i] == exp_rd[i], "R2 read order", log_q[i], exp_rd[i]);
            end
        end
    endtask

    task automatic check_idle_outputs(input string tag);
        chk({dev_req_o, xcvr_en_o, bus_ack_o, proto_err_o} == 4'b0000, tag,
            int'({dev_req_o, xcvr_en_o, bus_ack_o, proto_err_o}), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; rd = 0; wr = 0; dack_force = 0;
        repeat (3) @(negedge clk);
        check_idle_outputs("R1 outputs in reset");
        rst = 0;
        dev_on = 1;
        @(negedge clk);
        check_idle_outputs("R1 outputs after reset");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    bit [2:0] frozen;

    initial begin
        repeat (4) @(negedge clk);
        check_idle_outputs("R1 outputs in reset");
        rst = 0;
        @(negedge clk);
        check_idle_outputs("R1 outputs after reset");

        // ordered transfers, R2 and R3
        for (int i = 0; i < 4; i++) begin
            do_cycle(1'b0, 1'b1);
            do_cycle(1'b1, 1'b1);
        end
        // back-to-back mixed transfers, checked against the model (R9)
        for (int i = 0; i < 16; i++) do_cycle(1'($urandom_range(0, 1)), 1'b0);
        settle();
        chk(proto_err_o == 0, "R7 no error on legal traffic", int'(proto_err_o), 0);

        // R6: both strobes together
        rd = 1; wr = 1;
        repeat (5) @(negedge clk);
        chk(proto_err_o == 1, "R6 dual strobe error", int'(proto_err_o), 1);
        frozen = {dev_req_o, xcvr_en_o, bus_ack_o};
        rd = 0; wr = 0;
        repeat (8) @(negedge clk);
        chk(proto_err_o == 1, "R8 error sticky", int'(proto_err_o), 1);
        chk({dev_req_o, xcvr_en_o, bus_ack_o} == frozen, "R8 outputs frozen",
            int'({dev_req_o, xcvr_en_o, bus_ack_o}), int'(frozen));
        do_reset();

        // R7: device acknowledge without a request
        dev_on = 0; dack_force = 1;
        repeat (5) @(negedge clk);
        chk(proto_err_o == 1, "R7 ack without request", int'(proto_err_o), 1);
        dack_force = 0;
        repeat (4) @(negedge clk);
        chk(proto_err_o == 1, "R8 error sticky", int'(proto_err_o), 1);
        do_reset();

        // R7: read strobe dropped before the bus acknowledge
        dev_on = 0; dack_force = 0;
        rd = 1;
        while (!dev_req_o) @(negedge clk);
        rd = 0;
        repeat (6) @(negedge clk);
        chk(proto_err_o == 1, "R7 early strobe drop", int'(proto_err_o), 1);
        chk({dev_req_o, xcvr_en_o, bus_ack_o} == 3'b100, "R8 frozen in request phase",
            int'({dev_req_o, xcvr_en_o, bus_ack_o}), 4);
        do_reset();

        // R7: strobe rising while the bus acknowledge is still high
        rd = 1;
        while (!bus_ack_o) @(negedge clk);
        dack_force = 1; dev_on = 0;
        rd = 0;
        @(negedge clk);
        wr = 1;
        repeat (6) @(negedge clk);
        chk(proto_err_o == 1, "R7 strobe rise under bus ack", int'(proto_err_o), 1);
        chk(bus_ack_o == 1, "R8 bus ack held", int'(bus_ack_o), 1);
        do_reset();

        // traffic resumes after reset
        do_cycle(1'b1, 1'b1);
        do_cycle(1'b0, 1'b1);
        chk(proto_err_o == 0, "R1 clean after reset", int'(proto_err_o), 0);

        finish_run();
    end
endmodule